// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block sequences the start-up of a multiphase buck regulator. It runs on the phase clock. It raises a digital reference code from zero to the target given by a voltage-identification (VID) code, one LSB of 12.5 mV at a time. The ramp starts only after a fixed wait. The code that feeds the reference DAC is therefore a linear ramp.

The block also manages the power-stage drive enable. While a comparator reports that feedback is still above the ramping reference, the drivers stay off. This lets the regulator start into a pre-charged output without pulling it down. Three VID decode tables are supported. In each table a "no load" code sends the regulator into shutdown after a short delay, and a later valid code starts a fresh soft-start. A latched overvoltage fault overrides all VID activity until enable is cycled or reset is applied.

Top module: `softstart_seq`

## Requirements
- R1: While reset is low, and one cycle after `en` is sampled low, `ref_code` is 0 and `drv_en`, `pwm_en`, `ov_sd_sel` and `ss_done` are all low.
- R2: When `en` is sampled high with a valid VID code, `pwm_en` rises after that edge, and `ref_code` stays 0 for the first DLY_CYC cycles.
- R3: During the ramp, `ref_code` rises by exactly one per STEP_CYC cycles. It equals n once DLY_CYC + n*STEP_CYC edges have passed after the edge that started soft-start.
- R4: The target is the decoded VID in 12.5 mV units. For `mode` 0 it is (63 - vid)*2. For `mode` 1 it is (31 - vid[4:0])*2. For `mode` 2 or 3 it is (31 - vid[4:0])*4, and vid[5] is ignored in modes 1 to 3. The ramp stops exactly at the target, and `ss_done` is high from the cycle in which `ref_code` first equals the target.
- R5: `drv_en` stays low in the delay phase and during the ramp while `fb_above` is 1. It rises one cycle after `fb_above` is sampled 0 during the ramp, and it stays high even if `fb_above` returns to 1.
- R6: If `fb_above` is still 1 when the ramp reaches the target, `drv_en` rises in the same cycle as `ss_done`.
- R7: No-load codes are 62 and 63 in `mode` 0, and vid[4:0] = 31 in modes 1 to 3. Code 62 is a valid code in modes 1 to 3.
- R8: When a no-load code is sampled during delay, ramp or run, `pwm_en`, `ref_code` and `drv_en` hold for two more cycles. At the third edge `pwm_en` falls, `ov_sd_sel` rises and `ref_code` and `drv_en` go to 0.
- R9: In shutdown, a valid code sampled at an edge restarts soft-start from that edge: `pwm_en` goes high, `ov_sd_sel` goes low, and the timing of R2 and R3 applies again.
- R10: When `ov_fault` is sampled high in any active or shutdown state, the next cycle has `pwm_en`, `drv_en`, `ss_done` and `ov_sd_sel` low and `ref_code` 0. This latched state ignores every VID code and is left only through reset or through `en` low followed by `en` high.
- R11: If `en` rises while the VID code is a no-load code, the block goes straight to shutdown on that edge: `ov_sd_sel` is high and `pwm_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Controller enable |
| vid | input | 6 | VID code |
| mode | input | 2 | VID table select (0: 6-bit, 1: 5-bit fine, 2/3: 5-bit coarse) |
| fb_above | input | 1 | Comparator: feedback above the ramping reference |
| ov_fault | input | 1 | Overvoltage fault detected |
| ref_code | output | 8 | Reference code for the DAC, 12.5 mV per LSB |
| drv_en | output | 1 | Power-stage drive enable |
| pwm_en | output | 1 | PWM enable |
| ov_sd_sel | output | 1 | Selects the shutdown overvoltage trip level |
| ss_done | output | 1 | Soft-start complete, reference at target |

## Verification
The bench builds the block with DLY_CYC = 5 and STEP_CYC = 3. These are small, so even the 126-step full-scale ramp ends within a few hundred cycles. Because the two values are unequal, a delay counted with the step length, or a step counted with the delay length, lands on the wrong cycle and shows up in the trace comparison. A step length above one also separates "one increment per step window" from "one increment per cycle".

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int VID_W = 6;
  localparam int REF_W = 8;

  localparam logic [1:0] MODE_W6    = 2'd0;
  localparam logic [1:0] MODE_N5_25 = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_DELAY, S_RAMP, S_RUN, S_NLWAIT, S_OFF, S_OVLAT
  } seq_state_e;

  typedef enum logic [1:0] {R_CLR, R_INC, R_LOAD, R_HOLD} ref_op_e;

  // True for a code that requests the no-load shutdown.
  function automatic logic vid_is_off(input logic [1:0] mode,
                                      input logic [VID_W-1:0] vid);
    if (mode == MODE_W6) return (vid[5:1] == 5'h1F);
    return (vid[4:0] == 5'h1F);
  endfunction

  // Target reference in 12.5 mV LSBs.
  function automatic logic [REF_W-1:0] vid_target(input logic [1:0] mode,
                                                  input logic [VID_W-1:0] vid);
    logic [5:0] inv6;
    logic [4:0] inv5;
    inv6 = 6'd63 - vid;
    inv5 = 5'd31 - vid[4:0];
    if (mode == MODE_W6)    return {1'b0, inv6, 1'b0};
    if (mode == MODE_N5_25) return {2'b00, inv5, 1'b0};
    return {1'b0, inv5, 2'b00};
  endfunction
endpackage

// File: rtl/ssr_tick.sv
module ssr_tick #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || hit) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssr_ref.sv
module ssr_ref
  import ssr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ref_op_e          op,
  input  logic [REF_W-1:0] tgt,
  output logic [REF_W-1:0] ref_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else begin
      case (op)
        R_CLR:   ref_q <= '0;
        R_INC:   ref_q <= ref_q + 1'b1;
        R_LOAD:  ref_q <= tgt;
        default: ref_q <= ref_q;
      endcase
    end
  end
endmodule

// File: rtl/ssr_fsm.sv
module ssr_fsm
  import ssr_pkg::*;
#(
  parameter int DLY_CYC  = 16,
  parameter int STEP_CYC = 16,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             off_code,
  input  logic             fb_above,
  input  logic             ov_fault,
  input  logic             hit,
  input  logic [REF_W-1:0] tgt,
  input  logic [REF_W-1:0] ref_q,
  output seq_state_e       st_q,
  output logic             clr,
  output logic [CNT_W-1:0] lim,
  output ref_op_e          op,
  output logic             drv_q
);
  localparam logic [CNT_W-1:0] DLY_LIM  = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LIM = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] NL_LIM   = CNT_W'(1);

  seq_state_e st_n;
  logic [REF_W:0] ref_p1;
  logic reach, drv_n;

  assign ref_p1 = {1'b0, ref_q} + 1'b1;
  assign reach  = (ref_q >= tgt) || (hit && (ref_p1 >= {1'b0, tgt}));

  always_comb begin
    st_n = st_q;
    if (!en) st_n = S_IDLE;
    else if (st_q == S_IDLE) st_n = off_code ? S_OFF : S_DELAY;
    else if (st_q == S_OVLAT) st_n = S_OVLAT;
    else if (ov_fault) st_n = S_OVLAT;
    else begin
      case (st_q)
        S_DELAY:  if (off_code) st_n = S_NLWAIT; else if (hit) st_n = S_RAMP;
        S_RAMP:   if (off_code) st_n = S_NLWAIT; else if (reach) st_n = S_RUN;
        S_RUN:    if (off_code) st_n = S_NLWAIT;
        S_NLWAIT: if (hit) st_n = S_OFF;
        S_OFF:    if (!off_code) st_n = S_DELAY;
        default:  st_n = S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_n)
      S_RAMP:   op = (st_q == S_RAMP && hit) ? R_INC : R_HOLD;
      S_RUN:    op = R_LOAD;
      S_NLWAIT: op = R_HOLD;
      default:  op = R_CLR;
    endcase
  end

  always_comb begin
    case (st_n)
      S_RUN:    drv_n = 1'b1;
      S_RAMP:   drv_n = drv_q || (st_q == S_RAMP && !fb_above);
      S_NLWAIT: drv_n = drv_q;
      default:  drv_n = 1'b0;
    endcase
  end

  always_comb begin
    case (st_q)
      S_DELAY: lim = DLY_LIM;
      S_RAMP:  lim = STEP_LIM;
      default: lim = NL_LIM;
    endcase
  end

  assign clr = (st_n != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      drv_q <= drv_n;
    end
  end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ssr_pkg::*;
#(
  parameter int DLY_CYC  = 16,
  parameter int STEP_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VID_W-1:0] vid,
  input  logic [1:0]       mode,
  input  logic             fb_above,
  input  logic             ov_fault,
  output logic [REF_W-1:0] ref_code,
  output logic             drv_en,
  output logic             pwm_en,
  output logic             ov_sd_sel,
  output logic             ss_done
);
  localparam int MAXC  = (DLY_CYC > STEP_CYC) ? DLY_CYC : STEP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       st_q;
  ref_op_e          op;
  logic [REF_W-1:0] tgt, ref_q;
  logic [CNT_W-1:0] lim;
  logic             off_code, hit, clr, drv_q;
  logic             step_evt;

  assign tgt      = vid_target(mode, vid);
  assign off_code = vid_is_off(mode, vid);
  assign step_evt = hit && (st_q == S_RAMP);

  ssr_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lim(lim), .hit(hit)
  );

  ssr_fsm #(.DLY_CYC(DLY_CYC), .STEP_CYC(STEP_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .off_code(off_code),
    .fb_above(fb_above), .ov_fault(ov_fault), .hit(hit), .tgt(tgt),
    .ref_q(ref_q), .st_q(st_q), .clr(clr), .lim(lim), .op(op), .drv_q(drv_q)
  );

  ssr_ref u_ref (
    .clk(clk), .rst_n(rst_n), .op(op), .tgt(tgt), .ref_q(ref_q)
  );

  assign ref_code  = ref_q;
  assign drv_en    = drv_q;
  assign pwm_en    = (st_q == S_DELAY) || (st_q == S_RAMP) ||
                     (st_q == S_RUN)   || (st_q == S_NLWAIT);
  assign ov_sd_sel = (st_q == S_OFF);
  assign ss_done   = (st_q == S_RUN);
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk
  import ssr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             fb_above,
  input logic [REF_W-1:0] ref_code,
  input logic             drv_en,
  input logic             ss_done,
  input seq_state_e       st,
  input logic             step_evt
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> (ref_code == '0 && !drv_en));

  p_delay_ref_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DELAY |-> ref_code == '0);

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && $past(st) == S_RAMP) |->
      (ref_code == $past(ref_code) || ref_code == $past(ref_code) + 8'd1));

  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && $past(st) == S_RAMP && ref_code != $past(ref_code))
      |-> $past(step_evt));

  p_drv_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> (!$past(fb_above) || ss_done));

  p_drv_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && $past(st) == S_RAMP && $past(drv_en)) |-> drv_en);

  p_done_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> drv_en);

  p_off_after_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && $past(st) != S_OFF && $past(st) != S_IDLE) |->
      ($past(st) == S_NLWAIT && $past(st, 2) == S_NLWAIT));

  p_ovlat_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_OVLAT |-> (!drv_en && ref_code == '0 && !ss_done));

  p_ovlat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OVLAT && en) |=> st == S_OVLAT);
endmodule

bind softstart_seq ssr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_above(fb_above),
  .ref_code(ref_code), .drv_en(drv_en), .ss_done(ss_done),
  .st(st_q), .step_evt(step_evt)
);

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  localparam int CLK_NS = 10;
  localparam int DLY    = 5;
  localparam int STEP   = 3;
  localparam int NV     = 9;

  // {mode, vid, expected target}
  localparam logic [15:0] TBL [NV] = '{
    {2'd0, 6'd61, 8'd4},  {2'd0, 6'd0, 8'd126}, {2'd0, 6'd40, 8'd46},
    {2'd1, 6'd30, 8'd2},  {2'd1, 6'd0, 8'd62},  {2'd2, 6'd20, 8'd44},
    {2'd2, 6'b100101, 8'd104}, {2'd3, 6'd29, 8'd8}, {2'd1, 6'd62, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fb_above = 1'b0, ov_fault = 1'b0;
  logic [5:0] vid = 6'd0;
  logic [1:0] mode = 2'd0;
  logic [7:0] ref_code;
  logic drv_en, pwm_en, ov_sd_sel, ss_done;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  softstart_seq #(.DLY_CYC(DLY), .STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .vid(vid), .mode(mode),
    .fb_above(fb_above), .ov_fault(ov_fault), .ref_code(ref_code),
    .drv_en(drv_en), .pwm_en(pwm_en), .ov_sd_sel(ov_sd_sel), .ss_done(ss_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the bench at t = 0 (first sample after the starting edge).
  task automatic start_ss(input logic [1:0] m, input logic [5:0] v);
    en = 1'b0; cyc(2);
    mode = m; vid = v; en = 1'b1; cyc(1);
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " ref"}, ref_code, 0);
    chk({tag, " drv"}, drv_en, 0);
    chk({tag, " pwm"}, pwm_en, 0);
    chk({tag, " done"}, ss_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int mism, e, tg, lim;
    cyc(3);
    chk_quiet("R1 in reset");
    chk("R1 in reset ovsel", ov_sd_sel, 0);
    rst_n = 1'b1; cyc(1);

    // Table walk: R2, R3, R4, R5 (drive with fb low), R7 (code 62 valid in mode 1)
    for (int i = 0; i < NV; i++) begin
      fb_above = 1'b0;
      tg = int'(TBL[i][7:0]);
      start_ss(TBL[i][15:14], TBL[i][13:8]);
      lim = DLY + tg * STEP + 2;
      mism = 0;
      for (int t = 0; t <= lim; t++) begin
        e = (t < DLY) ? 0 : (t - DLY) / STEP;
        if (e > tg) e = tg;
        if (int'(ref_code) != e || pwm_en != 1'b1 || ss_done != (e == tg) ||
            drv_en != (t >= DLY + 1)) begin
          if (mism == 0)
            $display("FAIL R3 vector %0d t=%0d: actual ref %0d expected %0d", i, t, ref_code, e);
          mism++;
        end
        cyc(1);
      end
      n_chk++; if (mism != 0) n_err++;
      chk("R4 final ref", ref_code, tg);
      chk("R4 done", ss_done, 1);
    end

    // R5: pre-charged output holds drives off, then sticky enable
    fb_above = 1'b1;
    start_ss(2'd0, 6'd50);
    cyc(DLY + 3 * STEP);
    chk("R5 held ref", ref_code, 3);
    chk("R5 held drv", drv_en, 0);
    fb_above = 1'b0; cyc(1);
    chk("R5 drv rises", drv_en, 1);
    fb_above = 1'b1; cyc(2);
    chk("R5 drv sticky", drv_en, 1);

    // R6: feedback above reference all the way to target
    start_ss(2'd0, 6'd61);
    cyc(DLY + 4 * STEP - 1);
    chk("R6 before end ref", ref_code, 3);
    chk("R6 before end drv", drv_en, 0);
    cyc(1);
    chk("R6 end done", ss_done, 1);
    chk("R6 end drv", drv_en, 1);
    fb_above = 1'b0;

    // R8: no-load code in run, two-cycle wait
    start_ss(2'd0, 6'd61);
    cyc(DLY + 4 * STEP + 2);
    vid = 6'd62; cyc(1);
    chk("R8 wait1 pwm", pwm_en, 1);
    chk("R8 wait1 ovsel", ov_sd_sel, 0);
    cyc(1);
    chk("R8 wait2 pwm", pwm_en, 1);
    chk("R8 wait2 ref held", ref_code, 4);
    cyc(1);
    chk("R8 off pwm", pwm_en, 0);
    chk("R8 off ovsel", ov_sd_sel, 1);
    chk("R8 off ref", ref_code, 0);
    chk("R8 off drv", drv_en, 0);

    // R9: valid code restarts soft-start
    vid = 6'd61; cyc(1);
    chk("R9 restart pwm", pwm_en, 1);
    chk("R9 restart ovsel", ov_sd_sel, 0);
    chk("R9 restart ref", ref_code, 0);
    cyc(DLY + STEP);
    chk("R9 first step", ref_code, 1);

    // R7: 5-bit no-load code in mode 1, and code 63 in mode 0
    start_ss(2'd1, 6'd30);
    cyc(DLY + 2 * STEP + 1);
    vid = 6'b111111; cyc(3);
    chk("R7 mode1 off", ov_sd_sel, 1);
    start_ss(2'd0, 6'd40);
    cyc(DLY + 2);
    vid = 6'd63; cyc(3);
    chk("R7 mode0 code63 off", ov_sd_sel, 1);

    // R11: enable with a no-load code present
    en = 1'b0; cyc(2);
    mode = 2'd0; vid = 6'd63; en = 1'b1; cyc(1);
    chk("R11 ovsel", ov_sd_sel, 1);
    chk("R11 pwm", pwm_en, 0);

    // R10: latched overvoltage ignores VID codes
    start_ss(2'd0, 6'd50);
    cyc(DLY + 2 * STEP);
    ov_fault = 1'b1; cyc(1);
    ov_fault = 1'b0;
    chk_quiet("R10 latch");
    chk("R10 latch ovsel", ov_sd_sel, 0);
    vid = 6'd62; cyc(4);
    vid = 6'd50; cyc(DLY + STEP + 2);
    chk("R10 codes ignored pwm", pwm_en, 0);
    chk("R10 codes ignored ref", ref_code, 0);
    en = 1'b0; cyc(1);
    en = 1'b1; cyc(1);
    chk("R10 enable cycle pwm", pwm_en, 1);
    cyc(DLY + STEP);
    chk("R10 enable cycle ramp", ref_code, 1);

    // R1: enable low mid-ramp
    start_ss(2'd0, 6'd40);
    cyc(DLY + 2 * STEP + 1);
    en = 1'b0; cyc(1);
    chk_quiet("R1 en low");
    chk("R1 en low ovsel", ov_sd_sel, 0);

    // R1: reset in run
    start_ss(2'd0, 6'd61);
    cyc(DLY + 4 * STEP + 1);
    rst_n = 1'b0; cyc(1);
    chk_quiet("R1 reset mid-run");
    rst_n = 1'b1; cyc(1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule